// File: doc/BRIEF.md
# Machine-Cycle Timing Sequencer

This block produces the bus timing of a small 8-bit processor core. Each instruction is broken into machine cycles of four kinds: opcode fetch, operand read (a byte taken from the instruction stream), data read or write, and internal cycles that make no bus access. Inside each machine cycle the sequencer counts T-states from 1 up to that cycle's length, which is 3 to 6. Every T-state lasts two clocks, a first half and a second half. The sequencer drives the memory request, read, write and opcode-fetch strobes. It advances the program counter and a refresh counter, and it accepts maskable interrupts only when a whole instruction has finished.

Instructions arrive on a valid/ready port. An instruction is a 3-bit profile select, and a built-in table turns it into a list of machine-cycle kinds and lengths. Ready is high while the sequencer is idle. It is also high in the final clock of an instruction, so a waiting instruction starts with no gap. A producer holds valid and the profile stable until ready is seen at a clock edge. When valid is low the sequencer goes idle at the end of the current instruction. Interrupt enabling follows an enable/disable pair of profiles. An enable takes effect one instruction late.

Top module: `mcs_seq`

## Requirements
- R1: After reset, t_state is 0, all four strobes are low, pc and refresh are 0, inst_ready is 1, int_ack is 0 and interrupts are disabled.
- R2: An instruction is taken on a clock edge with inst_valid and inst_ready both high. inst_ready is low while busy, except in the last clock of an instruction. An instruction offered then begins with no idle clock.
- R3: Each T-state lasts exactly two clocks. t_state counts 1 up to the cycle's length and then moves on to the next machine cycle.
- R4: The profile table, with lengths in T-states, is: 0 = single fetch 4 (total 4); 1 = single fetch 6 (6); 2 = fetch 4, data read 3 (7); 3 = fetch 4, fetch 4, operand read 3, internal 5, data read 3 (19); 4 = fetch 4, data write 3 (7); 5 = interrupt enable, fetch 4 (4); 6 = interrupt disable, fetch 4 (4); 7 = fetch 4, operand read 3 (7).
- R5: In fetch, operand-read and data-read cycles, mreq and rd are high in the second clock of T1 and in both clocks of T2, and low otherwise.
- R6: In a write cycle, mreq is high in the second clock of T1 and in T2, and wr is high only in both clocks of T2. An internal cycle raises no strobe.
- R7: m1 is high for every clock of a fetch cycle and never in any other cycle.
- R8: pc rises by one at the end of each fetch and operand-read cycle. Data reads, writes and internal cycles leave it unchanged.
- R9: The low 7 bits of refresh rise by one, wrapping, at the end of each fetch cycle, prefix fetches included. Bit 7 never changes.
- R10: int_ack pulses only in the last clock of an instruction (inst_done), and only when irq is high and interrupts are enabled. Accepting an interrupt disables further ones.
- R11: After an enable instruction, no interrupt is accepted at its own end. Acceptance becomes possible from the end of the next instruction. A disable instruction turns acceptance off at once, pending enable included.
- R12: Memory cycles within each instruction happen in the order the profile lists them (fetch, read, write), one mreq pulse per memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | 1 | Instruction profile offered |
| inst_ready | output | 1 | Sequencer can take an instruction this clock |
| inst_prof | input | 3 | Instruction profile select |
| irq | input | 1 | Maskable interrupt request (level) |
| int_ack | output | 1 | Interrupt accepted at this instruction boundary |
| inst_done | output | 1 | Last clock of the current instruction |
| m_idx | output | 3 | Index of the current machine cycle within the instruction |
| t_state | output | 3 | Current T-state, 0 when idle |
| m1 | output | 1 | Opcode fetch cycle in progress |
| mreq | output | 1 | Memory request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| pc | output | 16 | Program counter |
| refresh | output | 8 | Refresh counter |

## Verification
Several properties are checked on every cycle:
- rd and wr are never high together, and rd always comes with mreq.
- A write never happens during an opcode fetch.
- t_state only advances after the second half of a T-state.
- pc never moves by more than one per clock, and the refresh top bit never moves.
- Interrupt acknowledges fall only on instruction boundaries.

Total T-state counts, the order of memory cycles, per-instruction increments of pc and refresh, and the delayed effect of enable and disable depend on whole instruction sequences. Only the bench's directed and random scenarios can show these.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int MAXM = 5;   // most machine cycles in one instruction
  localparam int TW   = 3;   // T-state counter width
  localparam int MW   = 3;   // machine-cycle index width
  localparam int PW   = 3;   // profile select width

  typedef enum logic [2:0] {
    MC_FETCH = 3'd0,
    MC_OPRD  = 3'd1,
    MC_RD    = 3'd2,
    MC_WR    = 3'd3,
    MC_INT   = 3'd4
  } mc_kind_e;

  typedef struct packed {
    logic [MW-1:0]             ncyc;
    logic [MAXM-1:0][2:0]      kind;
    logic [MAXM-1:0][TW-1:0]   len;
    logic                      is_ei;
    logic                      is_di;
  } prof_t;

  function automatic prof_t prof_lookup(input logic [PW-1:0] sel);
    prof_t p;
    p         = '0;
    p.ncyc    = MW'(1);
    p.kind[0] = MC_FETCH;
    p.len[0]  = TW'(4);
    case (sel)
      3'd1: p.len[0] = TW'(6);
      3'd2: begin
        p.ncyc = MW'(2); p.kind[1] = MC_RD; p.len[1] = TW'(3);
      end
      3'd3: begin
        p.ncyc    = MW'(5);
        p.kind[1] = MC_FETCH; p.len[1] = TW'(4);
        p.kind[2] = MC_OPRD;  p.len[2] = TW'(3);
        p.kind[3] = MC_INT;   p.len[3] = TW'(5);
        p.kind[4] = MC_RD;    p.len[4] = TW'(3);
      end
      3'd4: begin
        p.ncyc = MW'(2); p.kind[1] = MC_WR; p.len[1] = TW'(3);
      end
      3'd5: p.is_ei = 1'b1;
      3'd6: p.is_di = 1'b1;
      3'd7: begin
        p.ncyc = MW'(2); p.kind[1] = MC_OPRD; p.len[1] = TW'(3);
      end
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/mcs_tcount.sv
module mcs_tcount #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [TW-1:0] len,
  output logic [TW-1:0] t,
  output logic          ph,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t  <= '0;
      ph <= 1'b0;
    end else if (start) begin
      t  <= TW'(1);
      ph <= 1'b0;
    end else if (stop) begin
      t  <= '0;
      ph <= 1'b0;
    end else if (t != '0) begin
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        t  <= t + TW'(1);
      end
    end
  end

  assign last = (t != '0) && (t == len) && ph;

  AST_T_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (t != '0 && !ph && !start && !stop) |=> (t == $past(t) && ph)); // R3
  AST_T_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (t != '0) |-> (t <= len)); // R3
endmodule

// File: rtl/mcs_strobe.sv
module mcs_strobe #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [2:0]    kind,
  input  logic [TW-1:0] t,
  input  logic          ph,
  output logic          m1,
  output logic          mreq,
  output logic          rd,
  output logic          wr
);
  import mcs_pkg::*;
  logic mem_cyc, rd_cyc, win;

  always_comb begin
    mem_cyc = busy && (kind != MC_INT);
    rd_cyc  = (kind == MC_FETCH) || (kind == MC_OPRD) || (kind == MC_RD);
    win     = (t == TW'(1) && ph) || (t == TW'(2));
    mreq    = mem_cyc && win;
    rd      = mreq && rd_cyc;
    wr      = busy && (kind == MC_WR) && (t == TW'(2));
    m1      = busy && (kind == MC_FETCH);
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr)); // R6
  AST_RD_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> mreq); // R5
  AST_M1_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    m1 |-> !wr); // R7
endmodule

// File: rtl/mcs_irq.sv
module mcs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic is_ei,
  input  logic is_di,
  input  logic irq,
  output logic int_ack
);
  logic ie, pend;

  assign int_ack = done && irq && !is_ei && !is_di && (ie || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      pend <= 1'b0;
    end else if (done) begin
      if (is_di || int_ack) begin
        ie   <= 1'b0;
        pend <= 1'b0;
      end else if (is_ei) begin
        pend <= 1'b1;
      end else begin
        ie   <= ie || pend;
        pend <= 1'b0;
      end
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (!ie && !pend)); // R10
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_ack); // R11
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq #(
  parameter int PC_W = 16,
  parameter int RF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inst_valid,
  output logic            inst_ready,
  input  logic [2:0]      inst_prof,
  input  logic            irq,
  output logic            int_ack,
  output logic            inst_done,
  output logic [2:0]      m_idx,
  output logic [2:0]      t_state,
  output logic            m1,
  output logic            mreq,
  output logic            rd,
  output logic            wr,
  output logic [PC_W-1:0] pc,
  output logic [RF_W-1:0] refresh
);
  import mcs_pkg::*;

  prof_t         prof_q;
  logic [MW-1:0] midx;
  logic [TW-1:0] t, len_c;
  logic          ph, last, busy, final_m, cyc_end, take, tc_start, tc_stop;
  mc_kind_e      kind_c;

  always_comb begin
    kind_c     = mc_kind_e'(prof_q.kind[midx]);
    len_c      = prof_q.len[midx];
    busy       = (t != '0);
    final_m    = ((midx + MW'(1)) == prof_q.ncyc);
    cyc_end    = busy && last;
    inst_done  = cyc_end && final_m;
    inst_ready = !busy || inst_done;
    take       = inst_valid && inst_ready;
    tc_start   = take || (cyc_end && !final_m);
    tc_stop    = inst_done && !take;
  end

  mcs_tcount #(.TW(TW)) u_tc (
    .clk(clk), .rst_n(rst_n), .start(tc_start), .stop(tc_stop),
    .len(len_c), .t(t), .ph(ph), .last(last)
  );

  mcs_strobe #(.TW(TW)) u_st (
    .clk(clk), .rst_n(rst_n), .busy(busy), .kind(kind_c), .t(t), .ph(ph),
    .m1(m1), .mreq(mreq), .rd(rd), .wr(wr)
  );

  mcs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(inst_done), .is_ei(prof_q.is_ei),
    .is_di(prof_q.is_di), .irq(irq), .int_ack(int_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prof_q  <= '0;
      midx    <= '0;
      pc      <= '0;
      refresh <= '0;
    end else begin
      if (take) begin
        prof_q <= prof_lookup(inst_prof);
        midx   <= '0;
      end else if (cyc_end && !final_m) begin
        midx <= midx + MW'(1);
      end
      if (cyc_end && (kind_c == MC_FETCH || kind_c == MC_OPRD))
        pc <= pc + PC_W'(1);
      if (cyc_end && kind_c == MC_FETCH)
        refresh[RF_W-2:0] <= refresh[RF_W-2:0] + (RF_W-1)'(1);
    end
  end

  assign t_state = t;
  assign m_idx   = midx;

  AST_ACK_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (inst_done && irq)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pc == $past(pc) || pc == $past(pc) + PC_W'(1))); // R8
  AST_RF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(refresh[RF_W-1])); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state == 3'd0) |-> inst_ready); // R2
endmodule

// File: tb/test_mcs_seq.sv
module test_mcs_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic [2:0]  inst_prof = 3'd0;
  logic        irq = 1'b0;
  logic        inst_ready, int_ack, inst_done, m1, mreq, rd, wr;
  logic [2:0]  m_idx, t_state;
  logic [15:0] pc;
  logic [7:0]  refresh;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mcs_seq i_mcs_seq (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_prof(inst_prof), .irq(irq), .int_ack(int_ack), .inst_done(inst_done),
    .m_idx(m_idx), .t_state(t_state), .m1(m1), .mreq(mreq), .rd(rd), .wr(wr),
    .pc(pc), .refresh(refresh)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expectations straight from the profile table of R4
  task automatic expect_prof(input int p, output int tot, output int pcinc,
                             output int rfinc, output int nrd, output int nwr,
                             output int m1t, output int sig);
    tot = 4; pcinc = 1; rfinc = 1; nrd = 1; nwr = 0; m1t = 4; sig = 1;
    case (p)
      1: begin tot = 6; m1t = 6; end
      2: begin tot = 7; nrd = 2; sig = 6; end
      3: begin tot = 19; pcinc = 3; rfinc = 2; nrd = 4; m1t = 8; sig = 90; end
      4: begin tot = 7; nwr = 1; sig = 7; end
      7: begin tot = 7; pcinc = 2; nrd = 2; sig = 6; end
      default: ;
    endcase
  endtask

  int q[0:1023];
  int q_wr = 0, q_rd = 0;

  // monitor state
  int  acc_clk = 0, acc_rd = 0, acc_wr = 0, acc_m1 = 0, acc_mreq = 0, sig = 0;
  int  bad_ready = 0, stray_ack = 0;
  bit  prev_mreq = 0, chk_next = 0, run = 0;
  bit  m_ie = 0, m_pend = 0;
  int  exp_pc = 0, exp_rf = 0;

  always @(negedge clk) begin
    if (run) begin
      if (t_state != 3'd0) acc_clk++;
      if (rd) acc_rd++;
      if (wr) acc_wr++;
      if (m1) acc_m1++;
      if (mreq) acc_mreq++;
      if (mreq && !prev_mreq) sig = (sig * 4 + (m1 ? 1 : (rd ? 2 : 3))) & 1023;
      prev_mreq = mreq;
      if (t_state != 3'd0 && !inst_done && inst_ready) bad_ready++;
      if (int_ack && !inst_done) stray_ack++;
      if (chk_next) begin
        chk(pc == exp_pc[15:0], "R8 pc", int'(pc), exp_pc & 16'hffff);
        chk(refresh == exp_rf[7:0], "R9 refresh", int'(refresh), exp_rf);
        chk(refresh[7] == 1'b0, "R9 refresh top bit", int'(refresh[7]), 0);
        chk_next = 0;
      end
      if (inst_done) begin
        int p, tot, pci, rfi, nrd, nwr, m1t, esig;
        bit eack;
        p = q[q_rd % 1024]; q_rd++;
        expect_prof(p, tot, pci, rfi, nrd, nwr, m1t, esig);
        chk(acc_clk == 2 * tot, "R3/R4 clocks of instruction", acc_clk, 2 * tot);
        chk(acc_rd == 3 * nrd, "R5 rd clocks", acc_rd, 3 * nrd);
        chk(acc_wr == 2 * nwr, "R6 wr clocks", acc_wr, 2 * nwr);
        chk(acc_mreq == 3 * (nrd + nwr), "R6 mreq clocks", acc_mreq, 3 * (nrd + nwr));
        chk(acc_m1 == 2 * m1t, "R7 m1 clocks", acc_m1, 2 * m1t);
        chk(sig == esig, "R12 memory cycle order", sig, esig);
        chk(bad_ready == 0, "R2 ready while busy", bad_ready, 0);
        chk(stray_ack == 0, "R10 ack off boundary", stray_ack, 0);
        eack = irq && p != 5 && p != 6 && (m_ie || m_pend);
        chk(int_ack == eack, "R10/R11 int_ack", int'(int_ack), int'(eack));
        if (p == 6 || eack) begin m_ie = 0; m_pend = 0; end
        else if (p == 5) m_pend = 1;
        else begin m_ie = m_ie || m_pend; m_pend = 0; end
        exp_pc = (exp_pc + pci) & 16'hffff;
        exp_rf = (exp_rf + rfi) & 8'h7f;
        chk_next = 1;
        acc_clk = 0; acc_rd = 0; acc_wr = 0; acc_m1 = 0; acc_mreq = 0;
        sig = 0; bad_ready = 0; stray_ack = 0;
      end
    end
  end

  // called at posedge + 1; returns at posedge + 1 after the handshake edge
  task automatic issue(input int p);
    bit r;
    inst_valid = 1'b1;
    inst_prof  = p[2:0];
    forever begin
      @(negedge clk) r = inst_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
    q[q_wr % 1024] = p; q_wr++;
    inst_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    inst_valid = 1'b0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4021);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(t_state == 3'd0, "R1 t_state", int'(t_state), 0);
    chk({m1, mreq, rd, wr} == 4'b0, "R1 strobes", int'({m1, mreq, rd, wr}), 0);
    chk(pc == 16'd0, "R1 pc", int'(pc), 0);
    chk(refresh == 8'd0, "R1 refresh", int'(refresh), 0);
    chk(inst_ready == 1'b1, "R1 ready", int'(inst_ready), 1);
    chk(int_ack == 1'b0, "R1 ack", int'(int_ack), 0);
    run = 1;
    @(posedge clk); #1;

    // R11 enable delay, disable, acceptance clears
    irq = 1'b1;
    issue(0);            // disabled: no ack
    issue(5);            // enable: no ack at its own end
    issue(0);            // ack here
    issue(0);            // cleared by acceptance
    issue(5); issue(6); issue(0);   // disable wins over pending enable
    issue(5); issue(5); issue(3);   // ack at end of indexed instruction
    irq = 1'b0;
    idle(3);

    // each profile, isolated then back-to-back (R2, R4)
    for (int p = 0; p < 8; p++) begin issue(p); idle(2); end
    for (int p = 7; p >= 0; p--) issue(p);
    idle(2);

    // random mix
    for (int k = 0; k < 300; k++) begin
      irq = 1'($urandom % 2);
      issue(int'($urandom % 8));
      if ($urandom % 3 == 0) idle(int'($urandom % 3));
    end
    irq = 1'b0;
    idle(60);
    chk(q_rd == q_wr, "R2 all instructions completed", q_rd, q_wr);
    chk(t_state == 3'd0, "R2 idle after stream", int'(t_state), 0);
    summary();
  end
endmodule